// File: doc/BRIEF.md
# Reload-Match PWM Timer

This block generates a pulse-width-modulated output from an up-counter that never starts at zero. Instead of counting from zero to a period, the counter is preloaded with a value placed so that it reaches all-ones after exactly the requested number of cycles. On the edge after all-ones it reloads that value. A second stored value, the match point, marks the last cycle of the active phase. The output is high from the reload value through the match value. It is low from the match value plus one through all-ones.

A request front-end accepts a period and a duty, both given in clock cycles, on a write strobe. It turns them into a pending reload value and a pending match value. A period below two cycles is refused and flagged. A duty of zero is raised to one cycle. A duty that reaches or passes the period is cut to one cycle less than the period. Pending values reach the counter only when the timer is started from the stopped state, so a running waveform is never disturbed by a write.

Top module: `reload_pwm_timer`

## Requirements
- R1: After synchronous reset the timer is stopped, `pwmOut` is 0 and `cfgError` is 0.
- R2: While running, the output repeats with a period of exactly `periodCycles` clock cycles as last accepted before the start, with reload value = 2^32 − periodCycles.
- R3: Within each period `pwmOut` is 1 for the first `dutyCycles` cycles and 0 for the rest, starting with the first cycle after the start is sampled, for 1 ≤ dutyCycles < periodCycles.
- R4: A duty request of 0 gives an active phase of exactly 1 cycle.
- R5: A duty request equal to or larger than the period gives an active phase of periodCycles − 1 cycles.
- R6: A write with `periodCycles` below 2 sets `cfgError` to 1 in the cycle after the write, and the pending settings stay as they were.
- R7: A write with `periodCycles` of 2 or more clears `cfgError` in the cycle after the write.
- R8: A write while running does not change the running waveform; the new settings appear only after a stop and a new start.
- R9: While stopped, `pwmOut` is 0. A start request while running is ignored and keeps the phase. When start and stop are both requested in the same cycle, stop wins.
- R10: A start in the same cycle as a write uses the settings pending before that write; the written settings apply at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start the timer with the pending settings (ignored while running) |
| stopReq | input | 1 | Stop the timer; has priority over startReq |
| cfgWrite | input | 1 | Strobe that captures periodCycles and dutyCycles |
| periodCycles | input | 32 | Requested period in clock cycles |
| dutyCycles | input | 32 | Requested active time in clock cycles |
| cfgError | output | 1 | 1 when the last write was refused |
| pwmOut | output | 1 | PWM output, high during the active phase |

## Verification
The collision that matters is a settings write landing on the same edge as a start. The start must load the counter from the pending values as they stood before that edge, while the write updates the pending values on the same edge. The bench first leaves one setting pending, then raises the write strobe with a different setting together with the start request. It checks that the waveform matches the earlier setting cycle by cycle. After a stop and a fresh start it checks that the later setting has appeared. A second overlap, start and stop in one cycle, is judged by the output staying low.

// File: rtl/reload_pwm_pkg.sv
package reload_pwm_pkg;

  // Strobes from the request controller to the counting datapath.
  typedef struct packed {
    logic applyCfg;  // copy pending values into the counter and restart
    logic runEn;     // counter advances while set
  } pwmCtl_t;

endpackage

// File: rtl/pwm_req_ctrl.sv
module pwm_req_ctrl
  import reload_pwm_pkg::*;
#(
  parameter int unsigned CW         = 32,
  parameter int unsigned MIN_PERIOD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          startReq,
  input  logic          stopReq,
  input  logic          cfgWrite,
  input  logic [CW-1:0] periodReq,
  input  logic [CW-1:0] dutyReq,
  output pwmCtl_t       ctl,
  output logic [CW-1:0] pendLoad,
  output logic [CW-1:0] pendMatch,
  output logic          cfgError
);

  localparam logic [CW-1:0] ALL_ONES  = '1;
  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam logic [CW-1:0] MIN_PER_V = CW'(MIN_PERIOD);

  logic          runQ;
  logic          periodOk;
  logic [CW-1:0] dutyClamped;
  logic [CW-1:0] newLoad;
  logic [CW-1:0] newMatch;

  // Legalise the request: period floor, duty clamped into [1, period-1].
  always_comb begin
    periodOk = (periodReq >= MIN_PER_V);
    if (dutyReq == '0)
      dutyClamped = ONE;
    else if (dutyReq >= periodReq)
      dutyClamped = periodReq - ONE;
    else
      dutyClamped = dutyReq;
    newLoad  = (ALL_ONES - periodReq) + ONE;
    newMatch = newLoad + dutyClamped - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ      <= 1'b0;
      pendLoad  <= ALL_ONES - ONE;
      pendMatch <= ALL_ONES - ONE;
      cfgError  <= 1'b0;
    end else begin
      if (cfgWrite) begin
        if (periodOk) begin
          pendLoad  <= newLoad;
          pendMatch <= newMatch;
          cfgError  <= 1'b0;
        end else begin
          cfgError  <= 1'b1;
        end
      end
      if (stopReq)
        runQ <= 1'b0;
      else if (startReq)
        runQ <= 1'b1;
    end
  end

  always_comb begin
    ctl.applyCfg = startReq & ~stopReq & ~runQ;
    ctl.runEn    = runQ;
  end

endmodule

// File: rtl/pwm_count_path.sv
module pwm_count_path
  import reload_pwm_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  pwmCtl_t       ctl,
  input  logic [CW-1:0] pendLoad,
  input  logic [CW-1:0] pendMatch,
  output logic [CW-1:0] countVal,
  output logic [CW-1:0] loadVal,
  output logic [CW-1:0] matchVal,
  output logic          pwmOut
);

  localparam logic [CW-1:0] ALL_ONES = '1;
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] countQ;
  logic [CW-1:0] loadQ;
  logic [CW-1:0] matchQ;
  logic          atTop;

  assign atTop = (countQ == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
      loadQ  <= ALL_ONES - ONE;
      matchQ <= ALL_ONES - ONE;
    end else if (ctl.applyCfg) begin
      loadQ  <= pendLoad;
      matchQ <= pendMatch;
      countQ <= pendLoad;
    end else if (ctl.runEn) begin
      countQ <= atTop ? loadQ : countQ + ONE;
    end
  end

  assign pwmOut   = ctl.runEn & (countQ <= matchQ);
  assign countVal = countQ;
  assign loadVal  = loadQ;
  assign matchVal = matchQ;

endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import reload_pwm_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          startReq,
  input  logic          stopReq,
  input  logic          cfgWrite,
  input  logic [CW-1:0] periodCycles,
  input  logic [CW-1:0] dutyCycles,
  output logic          cfgError,
  output logic          pwmOut
);

  pwmCtl_t       ctlBus;
  logic [CW-1:0] pendLoad;
  logic [CW-1:0] pendMatch;
  logic [CW-1:0] countVal;
  logic [CW-1:0] loadVal;
  logic [CW-1:0] matchVal;
  logic          running;

  assign running = ctlBus.runEn;

  pwm_req_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startReq  (startReq),
    .stopReq   (stopReq),
    .cfgWrite  (cfgWrite),
    .periodReq (periodCycles),
    .dutyReq   (dutyCycles),
    .ctl       (ctlBus),
    .pendLoad  (pendLoad),
    .pendMatch (pendMatch),
    .cfgError  (cfgError)
  );

  pwm_count_path #(.CW(CW)) u_path (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctlBus),
    .pendLoad  (pendLoad),
    .pendMatch (pendMatch),
    .countVal  (countVal),
    .loadVal   (loadVal),
    .matchVal  (matchVal),
    .pwmOut    (pwmOut)
  );

endmodule

// File: rtl/reload_pwm_checker.sv
module reload_pwm_checker #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfgWrite,
  input logic          cfgError,
  input logic          pwmOut,
  input logic          running,
  input logic [CW-1:0] countVal,
  input logic [CW-1:0] loadVal,
  input logic [CW-1:0] matchVal
);

  localparam logic [CW-1:0] ALL_ONES = '1;

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst)
    !running |-> !pwmOut);  // R9

  AST_LEGAL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    running |-> (loadVal <= matchVal) && (matchVal != ALL_ONES));  // R3

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> countVal >= loadVal);  // R2

  AST_WRAP_TO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && $past(countVal) == ALL_ONES) |-> countVal == loadVal);  // R2

  AST_ERROR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(cfgError) |-> $past(cfgWrite));  // R6

endmodule

bind reload_pwm_timer reload_pwm_checker #(.CW(CW)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .cfgWrite (cfgWrite),
  .cfgError (cfgError),
  .pwmOut   (pwmOut),
  .running  (running),
  .countVal (countVal),
  .loadVal  (loadVal),
  .matchVal (matchVal)
);

// File: tb/reload_pwm_timer_tb.sv
module reload_pwm_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic        stopReq = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] periodCycles = '0;
  logic [31:0] dutyCycles = '0;
  logic        cfgError;
  logic        pwmOut;

  int checkCount = 0;
  int failCount  = 0;
  bit done       = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  reload_pwm_timer u_dut (
    .clk          (clk),
    .rst          (rst),
    .startReq     (startReq),
    .stopReq      (stopReq),
    .cfgWrite     (cfgWrite),
    .periodCycles (periodCycles),
    .dutyCycles   (dutyCycles),
    .cfgError     (cfgError),
    .pwmOut       (pwmOut)
  );

  // period, requested duty, expected active cycles
  localparam int unsigned NV = 8;
  localparam int unsigned TP [NV] = '{5, 2, 2, 6, 6, 6, 7, 10};
  localparam int unsigned TD [NV] = '{2, 1, 0, 0, 6, 9, 3, 7};
  localparam int unsigned TH [NV] = '{2, 1, 1, 1, 5, 5, 3, 7};

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Called at a negedge; sample index phase0 is the current cycle.
  task automatic checkWave(input string tag, input int p, input int h,
                           input int n, input int phase0);
    int bad = 0;
    int firstIdx = -1;
    logic firstAct = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic exp;
      exp = (((i + phase0) % p) < h);
      if (pwmOut !== exp) begin
        if (bad == 0) begin firstIdx = i; firstAct = pwmOut; end
        bad++;
      end
      @(negedge clk);
    end
    checkCount++;
    if (bad != 0) begin
      failCount++;
      $display("FAIL %s: %0d wrong samples, first at %0d actual %b expected %b",
               tag, bad, firstIdx, firstAct, ~firstAct);
    end
  endtask

  task automatic writeCfg(input int p, input int d);
    cfgWrite = 1'b1; periodCycles = p; dutyCycles = d;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic startPulse();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic stopPulse();
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkBit("R1 pwmOut in reset", pwmOut, 1'b0);
    checkBit("R1 cfgError in reset", cfgError, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    checkBit("R1 pwmOut after reset", pwmOut, 1'b0);

    // Vector table: R2/R3 waveform, R4 zero duty, R5 over-long duty
    for (int v = 0; v < NV; v++) begin
      string tag;
      if (TD[v] == 0) tag = "R4 zero duty";
      else if (TD[v] >= TP[v]) tag = "R5 long duty";
      else tag = "R2 R3 waveform";
      writeCfg(TP[v], TD[v]);
      startPulse();
      checkWave(tag, TP[v], TH[v], 3 * TP[v], 0);
      stopPulse();
    end

    // R6: short period refused, settings kept; R7: valid write clears flag
    writeCfg(5, 2);
    checkBit("R7 valid write clears error", cfgError, 1'b0);
    writeCfg(1, 0);
    checkBit("R6 period 1 flags error", cfgError, 1'b1);
    writeCfg(0, 0);
    checkBit("R6 period 0 flags error", cfgError, 1'b1);
    startPulse();
    checkWave("R6 settings kept", 5, 2, 15, 0);
    stopPulse();
    writeCfg(3, 1);
    checkBit("R7 error cleared", cfgError, 1'b0);

    // R8: write while running leaves the waveform alone
    writeCfg(5, 2);
    startPulse();
    checkWave("R8 before write", 5, 2, 10, 0);
    writeCfg(8, 4);
    checkWave("R8 write while running", 5, 2, 10, 11);
    // R9: start while running ignored, phase kept
    startPulse();
    checkWave("R9 start while running", 5, 2, 10, 22);
    stopPulse();
    checkWave("R9 stopped output low", 4, 0, 6, 0);
    startPulse();
    checkWave("R8 new settings after restart", 8, 4, 16, 0);
    stopPulse();
    // R9: start and stop together, stop wins
    startReq = 1'b1; stopReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; stopReq = 1'b0;
    checkWave("R9 stop wins over start", 4, 0, 8, 0);

    // R10: write and start in the same cycle
    writeCfg(4, 1);
    cfgWrite = 1'b1; periodCycles = 6; dutyCycles = 3; startReq = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0; startReq = 1'b0;
    checkWave("R10 start uses earlier settings", 4, 1, 12, 0);
    stopPulse();
    startPulse();
    checkWave("R10 later settings on restart", 6, 3, 12, 0);
    stopPulse();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule